// File: doc/BRIEF.md
# Beep Tone Generator

The beep tone generator produces a square-wave tone that is added into an audio output path. It runs once per audio sample, marked by a one-cycle sample strobe. Its output is a signed sample that stays at zero while the beep is silent. While the tone sounds, the sample alternates between plus and minus the selected level. The pitch is picked from sixteen note codes that cover just over two octaves of a major scale. The loudness comes from a volume code that is separate from every other gain in the path.

The tone is gated by a mode input. The single mode sounds one timed burst. The repeating mode alternates timed bursts with timed silences. The hold mode sounds until the mode is changed. Burst and silence lengths come from separate duration codes and are counted in samples. When the tone is switched off, the generator lets the half-cycle in progress complete before it falls silent, so the waveform is never chopped mid-cycle.

Top module: `beep_gen`

## Requirements
- R1: While reset is low, and from reset until the first sample strobe, `beep_out` is 0 and the generator is silent.
- R2: `beep_out` is registered and changes only on a clock edge at which `smp_stb` is high. Between strobes it holds its value.
- R3: Note code i (0..15) gives a half-period of H(i) = BASE_HALF*den[d] / (num[d] << (i/7)) samples, with d = i mod 7, num = {1,9,5,4,3,5,15} and den = {1,8,4,3,2,3,8}. The default BASE_HALF is 48, so code 0 gives 48 samples, code 7 gives 24, code 14 gives 12 and code 15 gives 10.
- R4: While sounding, the output level is A = vol << (DATA_W-1-VOL_W), which is vol·2^18 at the defaults. Each tone starts with H samples of +A, then H samples of −A, and keeps alternating. A silent sample is 0.
- R5: The mode encoding is 0 off, 1 single, 2 repeating, 3 hold. In mode 0, a silent generator stays at 0.
- R6: When the mode reaches 1 from any other value at a strobe while the generator is silent, one burst of (on_code+1)·ON_UNIT samples sounds, then the output returns to 0. Holding mode 1 does not sound again. The mode must leave 1 and return to re-arm the burst.
- R7: If the mode reaches 1 while a burst is sounding, the request is ignored. The burst is not restarted, and it ends when its remaining samples run out.
- R8: In mode 2, bursts of (on_code+1)·ON_UNIT samples alternate with silences of (off_code+1)·OFF_UNIT samples, and each burst starts on the positive half.
- R9: In mode 3 the burst length is ignored, and the tone sounds without a break.
- R10: When mode 0 is selected while the tone sounds, the current half-period finishes before the output goes to 0. When mode 0 is selected during a silence of mode 2, the generator goes idle at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe per audio sample |
| note_sel | input | 4 | Note code, 0 = lowest pitch |
| on_code | input | 4 | Burst length code |
| off_code | input | 3 | Silence length code |
| mode | input | 2 | 0 off, 1 single, 2 repeating, 3 hold |
| vol | input | 5 | Tone level code |
| beep_out | output | 24 | Signed tone sample |

## Verification
The mode and the codes are sampled at a strobe edge, and the sample computed there appears on `beep_out` right after that same edge. The first sample of a new burst is therefore due at the first strobe after the mode change. The bench moves its inputs only just after a strobe's result has been checked. It queues one expected sample for every following strobe, and compares each sample at the falling edge right after its strobe. Lengths of bursts, silences and half-periods are counted in strobes. A second compare just before each strobe confirms that the output held its value between strobes.

// File: rtl/beep_pkg.sv
package beep_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_ONCE   = 2'd1,
        MODE_REPEAT = 2'd2,
        MODE_HOLD   = 2'd3
    } beep_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TONE = 2'd1,
        ST_GAP  = 2'd2
    } beep_state_e;

    // scale degrees per octave in the note table
    localparam int NOTE_STEPS = 7;

endpackage

// File: rtl/beep_note_rom.sv
module beep_note_rom
    import beep_pkg::*;
#(
    parameter int NOTE_W    = 4,
    parameter int BASE_HALF = 48,
    parameter int HALF_W    = 6
) (
    input  logic [NOTE_W-1:0] note_sel,
    output logic [HALF_W-1:0] half_len
);
    localparam int NOTES = 2 ** NOTE_W;

    // Half-period in samples for one note: major-scale ratios, one octave per 7 codes
    function automatic int half_of(input int idx);
        int d;
        int o;
        int num;
        int den;
        d = idx % NOTE_STEPS;
        o = idx / NOTE_STEPS;
        case (d)
            0:       begin num = 1;  den = 1; end
            1:       begin num = 9;  den = 8; end
            2:       begin num = 5;  den = 4; end
            3:       begin num = 4;  den = 3; end
            4:       begin num = 3;  den = 2; end
            5:       begin num = 5;  den = 3; end
            default: begin num = 15; den = 8; end
        endcase
        return (BASE_HALF * den) / (num << o);
    endfunction

    logic [HALF_W-1:0] tbl [NOTES];

    for (genvar g = 0; g < NOTES; g++) begin : g_note
        assign tbl[g] = HALF_W'(half_of(g));
    end

    assign half_len = tbl[note_sel];

endmodule

// File: rtl/beep_span.sv
module beep_span #(
    parameter int ONT_W    = 4,
    parameter int OFFT_W   = 3,
    parameter int ON_UNIT  = 4128,
    parameter int OFF_UNIT = 57600,
    parameter int DUR_W    = 19
) (
    input  logic [ONT_W-1:0]  on_code,
    input  logic [OFFT_W-1:0] off_code,
    output logic [DUR_W-1:0]  on_len,
    output logic [DUR_W-1:0]  off_len
);
    // Lengths grow linearly with the code, counted in samples
    assign on_len  = DUR_W'((int'(on_code)  + 1) * ON_UNIT);
    assign off_len = DUR_W'((int'(off_code) + 1) * OFF_UNIT);

endmodule

// File: rtl/beep_level.sv
module beep_level #(
    parameter int DATA_W = 24,
    parameter int VOL_W  = 5
) (
    input  logic [VOL_W-1:0]         vol,
    output logic signed [DATA_W-1:0] amp_pos,
    output logic signed [DATA_W-1:0] amp_neg
);
    localparam int SHIFT = DATA_W - 1 - VOL_W;

    if (SHIFT >= 0) begin : g_up
        assign amp_pos = $signed(DATA_W'(vol) << SHIFT);
    end else begin : g_down
        assign amp_pos = $signed(DATA_W'(vol >> (-SHIFT)));
    end

    assign amp_neg = -amp_pos;

endmodule

// File: rtl/beep_gen.sv
module beep_gen
    import beep_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int VOL_W     = 5,
    parameter int NOTE_W    = 4,
    parameter int ONT_W     = 4,
    parameter int OFFT_W    = 3,
    parameter int BASE_HALF = 48,
    parameter int ON_UNIT   = 4128,
    parameter int OFF_UNIT  = 57600
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_stb,
    input  logic [NOTE_W-1:0]        note_sel,
    input  logic [ONT_W-1:0]         on_code,
    input  logic [OFFT_W-1:0]        off_code,
    input  logic [1:0]               mode,
    input  logic [VOL_W-1:0]         vol,
    output logic signed [DATA_W-1:0] beep_out
);
    localparam int HALF_W   = $clog2(BASE_HALF + 1);
    localparam int ON_MAX   = (2 ** ONT_W) * ON_UNIT;
    localparam int OFF_MAX  = (2 ** OFFT_W) * OFF_UNIT;
    localparam int SPAN_MAX = (ON_MAX > OFF_MAX) ? ON_MAX : OFF_MAX;
    localparam int DUR_W    = $clog2(SPAN_MAX + 1);

    typedef struct packed {
        beep_state_e              st;
        logic                     pos;
        logic [HALF_W-1:0]        half;
        logic [DUR_W-1:0]         dur;
        beep_mode_e               prev;
        logic signed [DATA_W-1:0] out;
    } regs_t;

    regs_t r_q, r_d;

    logic [HALF_W-1:0]        half_len;
    logic [DUR_W-1:0]         on_len;
    logic [DUR_W-1:0]         off_len;
    logic signed [DATA_W-1:0] amp_pos;
    logic signed [DATA_W-1:0] amp_neg;
    beep_mode_e               mode_e;
    logic                     once_req;

    beep_note_rom #(
        .NOTE_W   (NOTE_W),
        .BASE_HALF(BASE_HALF),
        .HALF_W   (HALF_W)
    ) u_rom (
        .note_sel(note_sel),
        .half_len(half_len)
    );

    beep_span #(
        .ONT_W   (ONT_W),
        .OFFT_W  (OFFT_W),
        .ON_UNIT (ON_UNIT),
        .OFF_UNIT(OFF_UNIT),
        .DUR_W   (DUR_W)
    ) u_span (
        .on_code (on_code),
        .off_code(off_code),
        .on_len  (on_len),
        .off_len (off_len)
    );

    beep_level #(
        .DATA_W(DATA_W),
        .VOL_W (VOL_W)
    ) u_level (
        .vol    (vol),
        .amp_pos(amp_pos),
        .amp_neg(amp_neg)
    );

    assign mode_e   = beep_mode_e'(mode);
    // single-burst request: mode has just entered MODE_ONCE
    assign once_req = (mode_e == MODE_ONCE) && (r_q.prev != MODE_ONCE);

    always_comb begin
        r_d = r_q;
        if (smp_stb) begin
            r_d.prev = mode_e;
            unique case (r_q.st)
                ST_IDLE: begin
                    if (mode_e == MODE_HOLD || mode_e == MODE_REPEAT || once_req) begin
                        r_d.st   = ST_TONE;
                        r_d.pos  = 1'b1;
                        r_d.half = half_len - HALF_W'(1);
                        r_d.dur  = on_len - DUR_W'(1);
                        r_d.out  = amp_pos;
                    end else begin
                        r_d.out = '0;
                    end
                end
                ST_TONE: begin
                    if (mode_e == MODE_OFF && r_q.half == '0) begin
                        // half-period complete: stop cleanly
                        r_d.st  = ST_IDLE;
                        r_d.out = '0;
                    end else if (mode_e != MODE_HOLD && r_q.dur == '0) begin
                        if (mode_e == MODE_REPEAT) begin
                            r_d.st  = ST_GAP;
                            r_d.dur = off_len - DUR_W'(1);
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                        r_d.out = '0;
                    end else begin
                        if (mode_e != MODE_HOLD) begin
                            r_d.dur = r_q.dur - DUR_W'(1);
                        end
                        if (r_q.half == '0) begin
                            r_d.pos  = ~r_q.pos;
                            r_d.half = half_len - HALF_W'(1);
                        end else begin
                            r_d.half = r_q.half - HALF_W'(1);
                        end
                        r_d.out = r_d.pos ? amp_pos : amp_neg;
                    end
                end
                ST_GAP: begin
                    if (mode_e != MODE_REPEAT) begin
                        r_d.st  = ST_IDLE;
                        r_d.out = '0;
                    end else if (r_q.dur == '0) begin
                        r_d.st   = ST_TONE;
                        r_d.pos  = 1'b1;
                        r_d.half = half_len - HALF_W'(1);
                        r_d.dur  = on_len - DUR_W'(1);
                        r_d.out  = amp_pos;
                    end else begin
                        r_d.dur = r_q.dur - DUR_W'(1);
                        r_d.out = '0;
                    end
                end
                default: begin
                    r_d.st  = ST_IDLE;
                    r_d.out = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pos: 1'b0, half: '0, dur: '0, prev: MODE_OFF, out: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign beep_out = r_q.out;

endmodule

// File: rtl/beep_gen_chk.sv
module beep_gen_chk #(
    parameter int DATA_W = 24,
    parameter int VOL_W  = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     smp_stb,
    input logic [1:0]               mode,
    input logic [VOL_W-1:0]         vol,
    input logic signed [DATA_W-1:0] beep_out
);
    localparam int SHIFT = DATA_W - 1 - VOL_W;

    logic signed [DATA_W-1:0] lvl;
    assign lvl = $signed(DATA_W'(vol) * (DATA_W'(1) << SHIFT));

    // R2: output only moves on a strobe edge
    assert_hold_between_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(beep_out));

    // R4: every sample is 0 or plus/minus the level taken at its strobe
    assert_sample_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (beep_out == '0 || beep_out == $past(lvl) || beep_out == -$past(lvl)));

    // R10: once silent with mode off, it stays silent
    assert_off_stays_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && mode == 2'd0 && beep_out == '0) |=> beep_out == '0);

    // R9: hold mode never drops to a silent sample while the level is nonzero
    assert_hold_no_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && mode == 2'd3 && vol != '0 && beep_out != '0) |=> beep_out != '0);

    // R8: a tone that starts from silence starts on the positive half
    assert_start_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && beep_out == '0) |=> beep_out >= 0);

endmodule

bind beep_gen beep_gen_chk #(
    .DATA_W(DATA_W),
    .VOL_W (VOL_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_stb (smp_stb),
    .mode    (mode),
    .vol     (vol),
    .beep_out(beep_out)
);

// File: tb/tb_beep_gen.sv
module tb_beep_gen;
    localparam int ON_U  = 20;
    localparam int OFF_U = 30;
    localparam int BASE  = 48;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_stb = 1'b0;
    logic [3:0]         note_sel = '0;
    logic [3:0]         on_code = '0;
    logic [2:0]         off_code = '0;
    logic [1:0]         mode = '0;
    logic [4:0]         vol = '0;
    logic signed [23:0] beep_out;

    int checks = 0;
    int errors = 0;
    int pend   = 0;
    logic signed [23:0] exp_q [$];
    string              tag_q [$];
    event               smp_done;

    always #2 clk = ~clk;

    beep_gen #(
        .BASE_HALF(BASE),
        .ON_UNIT  (ON_U),
        .OFF_UNIT (OFF_U)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_stb (smp_stb),
        .note_sel(note_sel),
        .on_code (on_code),
        .off_code(off_code),
        .mode    (mode),
        .vol     (vol),
        .beep_out(beep_out)
    );

    task automatic check(input string tag, input logic signed [23:0] act,
                         input logic signed [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic signed [23:0] lvl(input int v);
        return 24'(v) << 18;
    endfunction

    task automatic push_n(input logic signed [23:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(tag);
        end
        pend += n;
    endtask

    task automatic tone(input int h, input int v, input int pos_n, input int neg_n,
                        input string tag);
        if (h < 0) begin end
        push_n(lvl(v), pos_n, tag);
        push_n(-lvl(v), neg_n, tag);
    endtask

    task automatic run;
        repeat (pend) @(smp_done);
        pend = 0;
    endtask

    task automatic set(input int m, input int n, input int onc, input int offc, input int v);
        mode     = 2'(m);
        note_sel = 4'(n);
        on_code  = 4'(onc);
        off_code = 3'(offc);
        vol      = 5'(v);
    endtask

    task automatic finish_up;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // strobe generator and monitor: one strobe every 4 cycles
    initial begin
        logic signed [23:0] last;
        wait (rst_n);
        forever begin
            @(negedge clk);
            smp_stb = 1'b1;
            @(negedge clk);
            smp_stb = 1'b0;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), beep_out, exp_q.pop_front());
            end
            last = beep_out;
            ->smp_done;
            @(negedge clk);
            @(negedge clk);
            check("R2 hold between strobes", beep_out, last);
        end
    end

    // driver
    initial begin
        set(0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        check("R1 reset output", beep_out, 24'sd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset before strobe", beep_out, 24'sd0);

        push_n(0, 5, "R5 mode 0 silent");
        run();

        // single burst: note 15 (H=10), 60 samples, vol 7
        set(1, 15, 2, 0, 7);
        for (int i = 0; i < 3; i++) tone(10, 7, 10, 10, "R3/R6 single burst");
        push_n(0, 20, "R6 held mode 1 no retrigger");
        run();

        // re-arm: note 14 (H=12), 20 samples, vol 31
        set(0, 14, 0, 0, 31);
        push_n(0, 2, "R5 off");
        run();
        set(1, 14, 0, 0, 31);
        tone(12, 31, 12, 8, "R3/R4/R6 re-armed burst");
        push_n(0, 5, "R6 burst end");
        run();

        // repeating: note 7 (H=24), 40 on, 30 off, vol 1
        set(2, 7, 1, 0, 1);
        tone(24, 1, 24, 16, "R3/R8 first burst");
        push_n(0, 30, "R8 silence");
        tone(24, 1, 24, 16, "R8 second burst");
        run();
        set(0, 7, 1, 0, 1);
        push_n(0, 4, "R10 off at burst end");
        run();

        // mode 0 during a repeating silence goes idle at once
        set(2, 15, 0, 1, 2);
        tone(10, 2, 10, 10, "R8 burst");
        push_n(0, 10, "R8 silence");
        run();
        set(0, 15, 0, 1, 2);
        push_n(0, 3, "R10 off in silence");
        run();
        set(2, 15, 0, 1, 2);
        push_n(lvl(2), 10, "R10 silence was cancelled");
        run();
        set(0, 15, 0, 1, 2);
        push_n(0, 2, "R10 off at half end");
        run();

        // hold mode, then off mid-half: half must finish
        set(3, 15, 0, 0, 3);
        tone(10, 3, 10, 10, "R9 hold beyond burst length");
        push_n(lvl(3), 5, "R9 hold");
        run();
        set(0, 15, 0, 0, 3);
        push_n(lvl(3), 5, "R10 half finishes");
        push_n(0, 5, "R10 silent after half");
        run();

        // single request during a sounding burst is ignored
        set(2, 15, 1, 0, 2);
        tone(10, 2, 10, 5, "R8 burst start");
        run();
        set(1, 15, 1, 0, 2);
        push_n(-lvl(2), 5, "R7 burst continues");
        tone(10, 2, 10, 10, "R7 burst continues");
        push_n(0, 35, "R7 no restart");
        run();

        // lowest note in hold mode, stop at the period boundary
        set(3, 0, 0, 0, 31);
        tone(48, 31, 48, 48, "R3/R9 note 0");
        run();
        set(0, 0, 0, 0, 31);
        push_n(0, 3, "R10 stop at boundary");
        run();

        repeat (8) @(negedge clk);
        finish_up();
    end

    // watchdog
    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

endmodule